// File: doc/BRIEF.md
# SMBus Target Write-Transaction Decoder

This block is a target on a two-wire bus. It recovers host-to-target write transactions from the clock and data lines. Both lines are sampled with a faster system clock. The block finds start, repeated start and stop conditions and compares the 7-bit address against its own. It acknowledges each accepted byte by pulling the data line low through an open-drain enable.

The type of each transaction is decided when its stop arrives, from the number of bytes received after the address. The types are Quick Command (read or write), Send Byte and Write Byte. Send Byte and Write Byte can each carry a trailing packet error code (PEC). When PEC is enabled, the final byte is checked as a CRC-8 over all earlier bytes of the transaction. A good transaction produces a one-cycle valid strobe together with the command, the data and a type tag. A failed check produces a one-cycle error pulse in place of the strobe.

Top module: `smb_wr_decoder`

## Requirements
- R1: After reset, valid_o, pec_err_o and sda_oe_o are 0, and kind_o, cmd_o and data_o are 0.
- R2: If the 7-bit address that follows a start equals own_addr_i, the block drives the acknowledge slot low, for both read (R/W bit 1) and write (R/W bit 0). If the address does not match, SDA stays released in every slot and no strobe is produced until a later start.
- R3: A stop directly after an acknowledged address produces valid_o with kind_o = 1 for a write (R/W 0) or kind_o = 2 for a read (R/W 1). cmd_o and data_o are 0.
- R4: One byte before the stop produces kind_o = 3 (send), with cmd_o set to that byte and data_o = 0.
- R5: With pec_en_i = 0, two bytes produce kind_o = 5 (write), with cmd_o set to the first byte and data_o to the second.
- R6: With pec_en_i = 1, two bytes whose second byte equals the CRC of the address byte and the first byte produce kind_o = 4 (send with PEC), with cmd_o set to the first byte and data_o = 0.
- R7: With pec_en_i = 1, three bytes whose third byte is the correct CRC produce kind_o = 6 (write with PEC), with cmd_o and data_o set to the first two bytes. With pec_en_i = 0, three bytes produce neither a strobe nor an error.
- R8: A wrong PEC byte produces a one-cycle pulse on pec_err_o, no valid_o, and leaves kind_o, cmd_o and data_o unchanged.
- R9: The PEC is CRC-8 with polynomial 0x07 and initial value 0x00, taken MSB first over the address byte ({address, R/W}) and then each received byte before the PEC byte.
- R10: A repeated start discards the transaction in progress without a strobe and restarts address reception.
- R11: A fourth byte is not acknowledged, and the transaction is dropped. A stop in the middle of a byte also drops the transaction.
- R12: valid_o and pec_err_o last exactly one cycle each and are never high together. sda_oe_o changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| own_addr_i | input | 7 | Target address to match |
| pec_en_i | input | 1 | Treat the final byte as a packet error code |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| valid_o | output | 1 | One-cycle strobe for a good transaction |
| pec_err_o | output | 1 | One-cycle pulse for a PEC mismatch |
| kind_o | output | 3 | Transaction type tag, 1..6 as defined in R3 to R7 |
| cmd_o | output | 8 | Command code of the last good transaction |
| data_o | output | 8 | Data byte of the last good transaction |

## Verification
A wrong bit count or a wrong state shows up first in the acknowledge slots. The bench samples SDA at every ninth SCL high, so a misframed byte is seen within one byte time. A wrong byte count or a broken CRC chain only shows at the stop. There it gives a wrong tag, a missing strobe or a false error pulse a few system cycles later. A reference model is compared on every clock, so it also catches any extra strobe or error pulse.

// File: rtl/smb_wr_pkg.sv
package smb_wr_pkg;
  localparam int MAX_BYTES = 3;
  localparam int NB_W = $clog2(MAX_BYTES + 1);
  localparam logic [7:0] CRC_POLY = 8'h07;

  typedef enum logic [2:0] {
    K_NONE      = 3'd0,
    K_QUICK_WR  = 3'd1,
    K_QUICK_RD  = 3'd2,
    K_SEND      = 3'd3,
    K_SEND_PEC  = 3'd4,
    K_WRITE     = 3'd5,
    K_WRITE_PEC = 3'd6
  } txn_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_DATA, ST_RDWAIT
  } rx_state_e;

  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    c = crc ^ b;
    for (int i = 0; i < 8; i++)
      c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    return c;
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;  // idle bus is high
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_d_q, sda_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= scl_s_i;
      sda_d_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_d_q;
  assign scl_fall_o = ~scl_s_i & scl_d_q;
  assign start_o    = scl_s_i & scl_d_q & sda_d_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_d_q & ~sda_d_q & sda_s_i;
endmodule

// File: rtl/smb_txn_classify.sv
module smb_txn_classify
  import smb_wr_pkg::*;
(
  input  logic [7:0]      addr_byte_i,
  input  logic [7:0]      bytes_i [MAX_BYTES],
  input  logic [NB_W-1:0] nbytes_i,
  input  logic            pec_en_i,
  output txn_kind_e       kind_o,
  output logic [7:0]      cmd_o,
  output logic [7:0]      data_o,
  output logic            pec_bad_o,
  output logic            drop_o
);
  logic [7:0] crc_run [MAX_BYTES+1];

  // crc_run[k] covers the address byte plus the first k data bytes
  always_comb begin
    crc_run[0] = crc8_step(8'h00, addr_byte_i);
    for (int k = 0; k < MAX_BYTES; k++)
      crc_run[k+1] = crc8_step(crc_run[k], bytes_i[k]);
  end

  always_comb begin
    kind_o    = K_NONE;
    cmd_o     = 8'h00;
    data_o    = 8'h00;
    pec_bad_o = 1'b0;
    drop_o    = 1'b0;
    case (nbytes_i)
      NB_W'(0): kind_o = K_QUICK_WR;
      NB_W'(1): begin
        kind_o = K_SEND;
        cmd_o  = bytes_i[0];
      end
      NB_W'(2): begin
        cmd_o = bytes_i[0];
        if (pec_en_i) begin
          kind_o    = K_SEND_PEC;
          pec_bad_o = bytes_i[1] != crc_run[1];
        end else begin
          kind_o = K_WRITE;
          data_o = bytes_i[1];
        end
      end
      NB_W'(3): begin
        cmd_o  = bytes_i[0];
        data_o = bytes_i[1];
        kind_o = K_WRITE_PEC;
        if (pec_en_i) pec_bad_o = bytes_i[2] != crc_run[2];
        else          drop_o = 1'b1;
      end
      default: drop_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/smb_wr_decoder.sv
module smb_wr_decoder
  import smb_wr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [6:0] own_addr_i,
  input  logic       pec_en_i,
  output logic       sda_oe_o,
  output logic       valid_o,
  output logic       pec_err_o,
  output logic [2:0] kind_o,
  output logic [7:0] cmd_o,
  output logic [7:0] data_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, sync_lines;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_lines[g]),
      .q_o   (sync_lines[g])
    );
  end

  assign scl_s = sync_lines[1];
  assign sda_s = sync_lines[0];

  smb_bus_events u_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_s_i   (scl_s),
    .sda_s_i   (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_ev),
    .stop_o    (stop_ev)
  );

  rx_state_e       state_q;
  logic [3:0]      bit_cnt_q;
  logic [7:0]      shift_q, addr_q;
  logic [NB_W-1:0] nbytes_q;
  logic [7:0]      bytes_q [MAX_BYTES];
  logic            rd_q, oe_q, valid_q, pec_err_q;
  txn_kind_e       kind_q, cls_kind;
  logic [7:0]      cmd_q, data_q, cls_cmd, cls_data;
  logic            cls_bad, cls_drop;

  smb_txn_classify u_classify (
    .addr_byte_i(addr_q),
    .bytes_i    (bytes_q),
    .nbytes_i   (nbytes_q),
    .pec_en_i   (pec_en_i),
    .kind_o     (cls_kind),
    .cmd_o      (cls_cmd),
    .data_o     (cls_data),
    .pec_bad_o  (cls_bad),
    .drop_o     (cls_drop)
  );

  // the stop's own SCL rise counts one bit, so a clean boundary has bit_cnt_q == 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      addr_q    <= '0;
      nbytes_q  <= '0;
      for (int i = 0; i < MAX_BYTES; i++) bytes_q[i] <= '0;
      rd_q      <= 1'b0;
      oe_q      <= 1'b0;
      valid_q   <= 1'b0;
      pec_err_q <= 1'b0;
      kind_q    <= K_NONE;
      cmd_q     <= '0;
      data_q    <= '0;
    end else begin
      valid_q   <= 1'b0;
      pec_err_q <= 1'b0;
      if (start_ev) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        nbytes_q  <= '0;
        oe_q      <= 1'b0;
      end else if (stop_ev) begin
        if (state_q == ST_DATA && bit_cnt_q == 4'd1 && !cls_drop) begin
          if (cls_bad) pec_err_q <= 1'b1;
          else begin
            valid_q <= 1'b1;
            kind_q  <= cls_kind;
            cmd_q   <= cls_cmd;
            data_q  <= cls_data;
          end
        end else if (state_q == ST_RDWAIT && bit_cnt_q == 4'd1) begin
          valid_q <= 1'b1;
          kind_q  <= K_QUICK_RD;
          cmd_q   <= '0;
          data_q  <= '0;
        end
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise && bit_cnt_q < 4'd8) begin
              shift_q   <= {shift_q[6:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall && bit_cnt_q == 4'd8) begin
              bit_cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (shift_q[7:1] == own_addr_i) begin
                  addr_q  <= shift_q;
                  rd_q    <= shift_q[0];
                  oe_q    <= 1'b1;
                  state_q <= ST_ACK;
                end else state_q <= ST_IDLE;
              end else if (nbytes_q < NB_W'(MAX_BYTES)) begin
                for (int i = 0; i < MAX_BYTES; i++)
                  if (nbytes_q == NB_W'(i)) bytes_q[i] <= shift_q;
                nbytes_q <= nbytes_q + 1'b1;
                oe_q     <= 1'b1;
                state_q  <= ST_ACK;
              end else state_q <= ST_IDLE;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              oe_q      <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= rd_q ? ST_RDWAIT : ST_DATA;
            end
          end
          ST_RDWAIT: begin
            if (scl_rise && bit_cnt_q != 4'hF) bit_cnt_q <= bit_cnt_q + 4'd1;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign valid_o   = valid_q;
  assign pec_err_o = pec_err_q;
  assign kind_o    = kind_q;
  assign cmd_o     = cmd_q;
  assign data_o    = data_q;
endmodule

// File: rtl/smb_wr_decoder_chk.sv
module smb_wr_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       pec_en_i,
  input logic       sda_oe_o,
  input logic       valid_o,
  input logic       pec_err_o,
  input logic [2:0] kind_o,
  input logic [7:0] cmd_o,
  input logic [7:0] data_o
);
  a_r12_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && pec_err_o));

  a_r12_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r12_err_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pec_err_o |=> !pec_err_o);

  a_r12_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s));

  a_r8_err_needs_pec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pec_err_o |-> pec_en_i);

  a_r8_err_holds_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pec_err_o |-> ($stable(kind_o) && $stable(cmd_o) && $stable(data_o)));

  a_r3_quick_no_payload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (kind_o == 3'd1 || kind_o == 3'd2)) |-> (cmd_o == 8'h00 && data_o == 8'h00));

  a_r7_kind_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (kind_o >= 3'd1 && kind_o <= 3'd6));
endmodule

bind smb_wr_decoder smb_wr_decoder_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s    (scl_s),
  .pec_en_i (pec_en_i),
  .sda_oe_o (sda_oe_o),
  .valid_o  (valid_o),
  .pec_err_o(pec_err_o),
  .kind_o   (kind_o),
  .cmd_o    (cmd_o),
  .data_o   (data_o)
);

// File: tb/tb_smb_wr_decoder.sv
`timescale 1ns/1ps
module tb_smb_wr_decoder;
  localparam int Q = 5;  // system clocks per quarter SCL period
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_h = 1'b1, pec_en = 1'b0;
  logic sda_oe, valid, pec_err;
  logic [2:0] kind;
  logic [7:0] cmd, data;
  wire sda_line = sda_h & ~sda_oe;

  always #2.5 clk = ~clk;

  smb_wr_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .own_addr_i(OWN), .pec_en_i(pec_en), .sda_oe_o(sda_oe),
    .valid_o(valid), .pec_err_o(pec_err), .kind_o(kind),
    .cmd_o(cmd), .data_o(data)
  );

  typedef struct {int kind; logic [7:0] cmd; logic [7:0] data; bit perr; string tag;} exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] msg [5];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] ref_crc(input int len);
    logic [7:0] c = 8'h00;
    for (int b = 0; b < len; b++)
      for (int i = 7; i >= 0; i--) begin
        logic top;
        top = c[7] ^ msg[b][i];
        c = {c[6:0], 1'b0};
        if (top) c = c ^ 8'h07;
      end
    return c;
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_h = b; waitc(Q); scl = 1'b1; waitc(2*Q); scl = 1'b0; waitc(Q);
  endtask

  task automatic ack_slot(output logic a);
    sda_h = 1'b1; waitc(Q); scl = 1'b1; waitc(Q);
    @(negedge clk); a = sda_line;
    waitc(Q); scl = 1'b0; waitc(Q);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; waitc(Q); scl = 1'b1; waitc(Q); sda_h = 1'b0; waitc(Q); scl = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; waitc(Q); scl = 1'b1; waitc(Q); sda_h = 1'b1; waitc(2*Q);
  endtask

  task automatic byte_out(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    ack_slot(a);
    chk(a == !exp_ack, {tag, " ack slot"}, a, !exp_ack);
  endtask

  // msg[0] = {addr,rw}, msg[1..n] = bytes after address
  task automatic txn(input int n, input string tag);
    logic match, rw;
    exp_t e;
    match = msg[0][7:1] == OWN;
    rw = msg[0][0];
    bus_start();
    byte_out(msg[0], match, tag);
    for (int k = 1; k <= n; k++) byte_out(msg[k], match && !rw && k <= 3, tag);
    e.tag = tag; e.cmd = 8'h00; e.data = 8'h00; e.perr = 1'b0; e.kind = 0;
    if (match) begin
      if (rw) e.kind = (n == 0) ? 2 : 0;
      else if (n == 0) e.kind = 1;
      else if (n == 1) begin e.kind = 3; e.cmd = msg[1]; end
      else if (n == 2) begin
        e.cmd = msg[1];
        if (pec_en) begin
          e.kind = 4;
          e.perr = msg[2] != ref_crc(2);
        end else begin e.kind = 5; e.data = msg[2]; end
      end else if (n == 3 && pec_en) begin
        e.kind = 6; e.cmd = msg[1]; e.data = msg[2];
        e.perr = msg[3] != ref_crc(3);
      end
    end
    if (e.kind != 0) exp_q.push_back(e);
    bus_stop();
    waitc(4*Q);
    chk(exp_q.size() == 0, {tag, " strobe count"}, exp_q.size(), 0);
    chk(sda_oe == 1'b0, {tag, " SDA released at end"}, sda_oe, 0);
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n && (valid || pec_err)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R12 unexpected strobe", {valid, pec_err}, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(!(valid && pec_err), {e.tag, " R12 exclusive"}, {valid, pec_err}, {!e.perr, e.perr});
        chk(pec_err == e.perr, {e.tag, " pec_err"}, pec_err, e.perr);
        if (!e.perr) begin
          chk(int'(kind) == e.kind, {e.tag, " kind"}, kind, e.kind);
          chk(cmd == e.cmd, {e.tag, " cmd"}, cmd, e.cmd);
          chk(data == e.data, {e.tag, " data"}, data, e.data);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    waitc(3);
    @(negedge clk);
    chk(valid == 0 && pec_err == 0 && sda_oe == 0, "R1 reset strobes", {valid, pec_err, sda_oe}, 0);
    chk(kind == 0 && cmd == 0 && data == 0, "R1 reset fields", {kind, cmd, data}, 0);
    rst_n = 1'b1;
    waitc(10);

    msg[0] = {OWN, 1'b0}; txn(0, "R3 R2 quick write");
    msg[0] = {OWN, 1'b1}; txn(0, "R3 R2 quick read");
    msg[0] = {OWN, 1'b0}; msg[1] = 8'h9C; txn(1, "R4 send byte");
    msg[1] = 8'h21; msg[2] = 8'hE5; txn(2, "R5 write byte");
    msg[1] = 8'h00; msg[2] = 8'hFF; txn(2, "R5 write byte edge values");

    pec_en = 1'b1; waitc(4);
    msg[1] = 8'h03; msg[2] = ref_crc(2); txn(2, "R6 R9 send with pec");
    msg[1] = 8'h01; msg[2] = 8'h80; msg[3] = ref_crc(3); txn(3, "R7 R9 write with pec");
    msg[1] = 8'h01; msg[2] = 8'h80; msg[3] = ref_crc(3) ^ 8'h10; txn(3, "R8 bad pec write");
    msg[1] = 8'h03; msg[2] = ref_crc(2) ^ 8'h01; txn(2, "R8 bad pec send");
    @(negedge clk);
    chk(kind == 3'd6 && cmd == 8'h01 && data == 8'h80, "R8 fields held after error", {kind, cmd, data}, {3'd6, 8'h01, 8'h80});
    msg[1] = 8'h77; txn(1, "R4 send byte with pec enabled");

    pec_en = 1'b0; waitc(4);
    msg[1] = 8'h11; msg[2] = 8'h22; msg[3] = 8'h33; txn(3, "R7 three bytes pec off dropped");
    msg[4] = 8'h44; msg[1] = 8'h11; txn(4, "R11 fourth byte nack");

    msg[0] = {OWN ^ 7'h01, 1'b0}; msg[1] = 8'h55; txn(1, "R2 address mismatch");

    // repeated start discards partial transaction
    bus_start();
    byte_out({OWN, 1'b0}, 1'b1, "R10 first address");
    byte_out(8'hAB, 1'b1, "R10 first byte");
    msg[0] = {OWN, 1'b0}; msg[1] = 8'h3C; txn(1, "R10 after repeated start");

    // stop in the middle of a byte
    bus_start();
    byte_out({OWN, 1'b0}, 1'b1, "R11 partial address");
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    bus_stop();
    waitc(4*Q);
    chk(exp_q.size() == 0, "R11 stop mid byte dropped", exp_q.size(), 0);

    msg[0] = {OWN, 1'b0}; msg[1] = 8'hC3; txn(1, "R4 send byte after drop");

    waitc(10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule